// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block is a bit-manipulation engine built around a 128-bit store in which every bit has its own 7-bit address, plus a one-bit carry register that serves as the accumulator for boolean work. Each cycle it accepts at most one command: an opcode and a bit address. A command can force a stored bit or the carry to one, force it to zero, or invert it. It can fold a stored bit, or the inverse of that bit, into the carry with AND or OR. It can copy a bit into the carry, or the carry into a bit.

The block also evaluates the conditions behind bit-testing branches. It tests a stored bit for one or for zero, tests the carry for one or for zero, and has a test-then-clear form. It reports the outcome on `taken_o` in the same cycle as the command. Computing the branch target is left to the surrounding sequencer. All state changes take effect on the next rising clock edge.

A separate byte-write port loads eight adjacent bits at once. Bit `k` of byte index `j` lives at bit address `8*j + k`. The `bit_o` output always shows the present value of the bit named by `cmd_addr_i`, before any update.

Top module: `bool_proc`

## Requirements
- R1: While `rst_n` is low, all 128 bits and the carry are cleared. After reset, `carry_o` is 0 and `bit_o` reads 0 at every address.
- R2: With `cmd_valid_i` high, opcode 1 sets, opcode 2 clears and opcode 3 inverts the bit at `cmd_addr_i` on the next edge. The carry and all other bits are left unchanged.
- R3: Opcode 4 sets, opcode 5 clears and opcode 6 inverts the carry on the next edge. No bit of the store changes.
- R4: Opcode 7 makes carry = carry AND bit, and opcode 9 makes carry = carry OR bit. The addressed bit is not modified.
- R5: Opcode 8 makes carry = carry AND (NOT bit), and opcode 10 makes carry = carry OR (NOT bit). The addressed bit keeps its stored value.
- R6: Opcode 11 copies the addressed bit into the carry. Opcode 12 copies the carry into the addressed bit.
- R7: In the cycle of the command, `taken_o` equals the addressed bit for opcode 13 and its inverse for opcode 14. It equals the carry for opcode 16 and the inverse of the carry for opcode 17. None of these change any state.
- R8: For opcode 15, `taken_o` equals the addressed bit. If the bit was 1 it is cleared on the next edge; if it was 0 it stays 0.
- R9: With `byte_we_i` high, the bits at addresses `8*byte_idx_i + k` take `byte_data_i[k]` on the next edge.
- R10: When a bit-writing command and a byte write hit the same byte in one cycle, the addressed bit takes the command's value. The other seven bits take the byte data.
- R11: With `cmd_valid_i` low, or with opcode 0 or any opcode above 17, `taken_o` is 0 and the command changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 5 | Opcode, values as in R2 to R8 |
| cmd_addr_i | input | 7 | Bit address of the command operand |
| byte_we_i | input | 1 | Byte write enable |
| byte_idx_i | input | 4 | Byte index for the byte write |
| byte_data_i | input | 8 | Byte write data, bit k to address 8*idx+k |
| taken_o | output | 1 | Branch condition result, same cycle |
| carry_o | output | 1 | Current carry |
| bit_o | output | 1 | Current value of the bit at cmd_addr_i |

## Verification
The hardest case to reach is a bit-writing command and a byte write that land in the same byte on the same edge. The outcome is only correct if the priority is resolved per bit, without disturbing the seven neighbours. The bench drives every byte index together with a set or clear of one bit inside it, and uses byte data opposite to the commanded value. It then reads all 128 bits back through `bit_o`. The test-then-clear form is run over every address with random memory contents, so it meets both the set and the clear case.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 5'd0,
    OP_SET_BIT  = 5'd1,
    OP_CLR_BIT  = 5'd2,
    OP_INV_BIT  = 5'd3,
    OP_SET_C    = 5'd4,
    OP_CLR_C    = 5'd5,
    OP_INV_C    = 5'd6,
    OP_AND_B    = 5'd7,
    OP_AND_NB   = 5'd8,
    OP_OR_B     = 5'd9,
    OP_OR_NB    = 5'd10,
    OP_LOAD_C   = 5'd11,
    OP_STORE_C  = 5'd12,
    OP_T_ONE    = 5'd13,
    OP_T_ZERO   = 5'd14,
    OP_T_ONECLR = 5'd15,
    OP_T_C      = 5'd16,
    OP_T_NC     = 5'd17
  } bp_op_e;

  // {write_enable, value} for the carry register
  function automatic logic [1:0] bp_carry_next(bp_op_e op, logic c, logic b);
    case (op)
      OP_SET_C:  return 2'b11;
      OP_CLR_C:  return 2'b10;
      OP_INV_C:  return {1'b1, ~c};
      OP_AND_B:  return {1'b1, c & b};
      OP_AND_NB: return {1'b1, c & ~b};
      OP_OR_B:   return {1'b1, c | b};
      OP_OR_NB:  return {1'b1, c | ~b};
      OP_LOAD_C: return {1'b1, b};
      default:   return 2'b00;
    endcase
  endfunction

  // {write_enable, value} for the addressed bit
  function automatic logic [1:0] bp_bit_next(bp_op_e op, logic c, logic b);
    case (op)
      OP_SET_BIT:  return 2'b11;
      OP_CLR_BIT:  return 2'b10;
      OP_INV_BIT:  return {1'b1, ~b};
      OP_STORE_C:  return {1'b1, c};
      OP_T_ONECLR: return {b, 1'b0};
      default:     return 2'b00;
    endcase
  endfunction

  function automatic logic bp_cond(bp_op_e op, logic c, logic b);
    case (op)
      OP_T_ONE, OP_T_ONECLR: return b;
      OP_T_ZERO:             return ~b;
      OP_T_C:                return c;
      OP_T_NC:               return ~c;
      default:               return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bp_exec.sv
module bp_exec
  import bp_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            carry_i,
  input  logic            bit_i,
  output logic            bit_we_o,
  output logic            bit_val_o,
  output logic            c_we_o,
  output logic            c_val_o
);
  bp_op_e     op;
  logic [1:0] bn, cn;

  always_comb begin
    op = bp_op_e'(op_i);
    bn = bp_bit_next(op, carry_i, bit_i);
    cn = bp_carry_next(op, carry_i, bit_i);
    bit_we_o  = valid_i & bn[1];
    bit_val_o = bn[0];
    c_we_o    = valid_i & cn[1];
    c_val_o   = cn[0];
  end
endmodule

// File: rtl/bp_cond_eval.sv
module bp_cond_eval
  import bp_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            carry_i,
  input  logic            bit_i,
  output logic            taken_o
);
  always_comb taken_o = valid_i & bp_cond(bp_op_e'(op_i), carry_i, bit_i);
endmodule

// File: rtl/bp_bitmem.sv
module bp_bitmem #(
  parameter int N_BITS = 128,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(N_BITS),
  localparam int NBY   = N_BITS / BYTE_W,
  localparam int BIW   = $clog2(NBY),
  localparam int SHW   = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_we_i,
  input  logic [AW-1:0]     bit_addr_i,
  input  logic              bit_val_i,
  input  logic              byte_we_i,
  input  logic [BIW-1:0]    byte_idx_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  output logic              rd_bit_o,
  output logic [N_BITS-1:0] mem_o
);
  logic [N_BITS-1:0] mem_q;

  for (genvar i = 0; i < N_BITS; i++) begin : g_cell
    logic hit_bit, hit_byte;
    assign hit_bit  = bit_we_i  && (bit_addr_i == AW'(i));
    assign hit_byte = byte_we_i && (byte_idx_i == BIW'(i / BYTE_W));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem_q[i] <= 1'b0;
      else if (hit_bit)  mem_q[i] <= bit_val_i;
      else if (hit_byte) mem_q[i] <= byte_data_i[i % BYTE_W];
    end
  end

  assign rd_bit_o = mem_q[bit_addr_i];
  assign mem_o    = mem_q;

  // R10: bit command wins over byte write
  p_bit_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we_i && byte_we_i |=> mem_q[$past(bit_addr_i)] == $past(bit_val_i));

  // R9: byte lands when no bit write shares its byte
  p_byte_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we_i && !bit_we_i |=>
      mem_q[{$past(byte_idx_i), {SHW{1'b0}}} +: BYTE_W] == $past(byte_data_i));

  // R11: no writer, no change
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_we_i && !byte_we_i |=> $stable(mem_q));
endmodule

// File: rtl/bool_proc.sv
module bool_proc
  import bp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [4:0] cmd_op_i,
  input  logic [6:0] cmd_addr_i,
  input  logic       byte_we_i,
  input  logic [3:0] byte_idx_i,
  input  logic [7:0] byte_data_i,
  output logic       taken_o,
  output logic       carry_o,
  output logic       bit_o
);
  localparam int N_BITS = 128;
  localparam int BYTE_W = 8;

  logic              carry_q;
  logic              cur_bit;
  logic              bit_we, bit_val, c_we, c_val;
  logic [N_BITS-1:0] mem_view;

  bp_exec u_exec (
    .valid_i(cmd_valid_i), .op_i(cmd_op_i), .carry_i(carry_q), .bit_i(cur_bit),
    .bit_we_o(bit_we), .bit_val_o(bit_val), .c_we_o(c_we), .c_val_o(c_val)
  );

  bp_cond_eval u_cond (
    .valid_i(cmd_valid_i), .op_i(cmd_op_i), .carry_i(carry_q), .bit_i(cur_bit),
    .taken_o(taken_o)
  );

  bp_bitmem #(.N_BITS(N_BITS), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .bit_we_i(bit_we), .bit_addr_i(cmd_addr_i), .bit_val_i(bit_val),
    .byte_we_i(byte_we_i), .byte_idx_i(byte_idx_i), .byte_data_i(byte_data_i),
    .rd_bit_o(cur_bit), .mem_o(mem_view)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    carry_q <= 1'b0;
    else if (c_we) carry_q <= c_val;
  end

  assign carry_o = carry_q;
  assign bit_o   = cur_bit;

  // R3: set-carry command leaves carry at one
  p_set_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_op_i == 5'd4 |=> carry_q);

  // R8: after test-then-clear the bit is zero in either case
  p_test_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_op_i == 5'd15 && !byte_we_i |=> !mem_view[$past(cmd_addr_i)]);

  // R5: inverted-operand AND keeps the stored bit
  p_and_inv_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_op_i == 5'd8 && !byte_we_i |=>
      mem_view[$past(cmd_addr_i)] == $past(cur_bit));

  // R11: no command, no taken
  p_taken_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_i |-> !taken_o);

  // R7: carry tests never disturb carry
  p_carry_test_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && (cmd_op_i == 5'd16 || cmd_op_i == 5'd17) |=> $stable(carry_q));
endmodule

// File: tb/bool_proc_tb_top.sv
`timescale 1ns/1ps
module bool_proc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [4:0] cmd_op_i = '0;
  logic [6:0] cmd_addr_i = '0;
  logic       byte_we_i = 1'b0;
  logic [3:0] byte_idx_i = '0;
  logic [7:0] byte_data_i = '0;
  logic       taken_o, carry_o, bit_o;

  int tests = 0;
  int fails = 0;
  logic [127:0] m = '0;
  logic         c = 1'b0;

  always #5 clk = ~clk;

  bool_proc dut_i (.*);

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    for (int a = 0; a < 128; a++) begin
      cmd_addr_i = 7'(a);
      #0.05;
      chk(bit_o, m[a], req, $sformatf("bit %0d", a));
    end
    chk(carry_o, c, req, "carry");
  endtask

  function automatic string tag_of(input int op);
    if (op >= 1 && op <= 3)   return "R2";
    if (op >= 4 && op <= 6)   return "R3";
    if (op == 7 || op == 9)   return "R4";
    if (op == 8 || op == 10)  return "R5";
    if (op == 11 || op == 12) return "R6";
    if (op == 15)             return "R8";
    if (op >= 13 && op <= 17) return "R7";
    return "R11";
  endfunction

  task automatic cmd(input logic v, input int op, input int a,
                     input logic bwe, input int bidx, input logic [7:0] bdat);
    logic b, exp_t;
    string req;
    req = tag_of(op);
    @(negedge clk);
    cmd_valid_i = v; cmd_op_i = 5'(op); cmd_addr_i = 7'(a);
    byte_we_i = bwe; byte_idx_i = 4'(bidx); byte_data_i = bdat;
    #1;
    b = m[a];
    chk(bit_o, b, req, "operand view");
    exp_t = 1'b0;
    if (v) case (op)
      13, 15: exp_t = b;
      14:     exp_t = ~b;
      16:     exp_t = c;
      17:     exp_t = ~c;
      default: exp_t = 1'b0;
    endcase
    if (!v) req = "R11";
    chk(taken_o, exp_t, req, "taken");
    @(posedge clk);
    if (bwe) for (int k = 0; k < 8; k++) m[bidx*8+k] = bdat[k];
    if (v) case (op)
      1: m[a] = 1'b1;
      2: m[a] = 1'b0;
      3: m[a] = ~b;
      4: c = 1'b1;
      5: c = 1'b0;
      6: c = ~c;
      7: c = c & b;
      8: c = c & ~b;
      9: c = c | b;
      10: c = c | ~b;
      11: c = b;
      12: m[a] = c;
      15: if (b) m[a] = 1'b0;
      default: ;
    endcase
    #1;
    chk(carry_o, c, req, "carry after");
    chk(bit_o, m[a], req, "bit after");
    @(negedge clk);
    cmd_valid_i = 1'b0; byte_we_i = 1'b0;
  endtask

  task automatic fill_random();
    for (int j = 0; j < 16; j++) cmd(1'b0, 0, 0, 1'b1, j, 8'($urandom));
  endtask

  initial begin
    #1_500_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(carry_o, 1'b0, "R1", "carry in reset");
    rst_n = 1'b1;
    sweep("R1");

    // R9: byte pattern per index
    for (int j = 0; j < 16; j++) cmd(1'b0, 0, 0, 1'b1, j, 8'((j * 37) ^ 8'hA5));
    sweep("R9");

    // R2..R8: every opcode over every address
    for (int op = 1; op <= 17; op++) begin
      fill_random();
      for (int a = 0; a < 128; a++) begin
        if ($urandom % 2) cmd(1'b1, 6, 0, 1'b0, 0, 8'h00);
        cmd(1'b1, op, a, 1'b0, 0, 8'h00);
      end
      sweep(tag_of(op));
    end

    // R10: bit command and byte write to the same byte
    for (int j = 0; j < 16; j++) begin
      cmd(1'b1, 1, j*8 + (j % 8), 1'b1, j, 8'h00);
      cmd(1'b1, 2, j*8 + ((j+3) % 8), 1'b1, j, 8'hFF);
    end
    sweep("R10");

    // R11: invalid and idle opcodes change nothing
    fill_random();
    for (int a = 0; a < 128; a += 7) begin
      cmd(1'b0, 3, a, 1'b0, 0, 8'h00);
      cmd(1'b0, 15, a, 1'b0, 0, 8'h00);
      cmd(1'b1, 0, a, 1'b0, 0, 8'h00);
      cmd(1'b1, 18 + (a % 14), a, 1'b0, 0, 8'h00);
    end
    sweep("R11");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule